// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is one general-purpose I/O port of up to eight pins. Each pin has its own 32-byte register window on a simple word-addressed write bus with a combinational read path. Through that window software enables the pin and picks its direction. It can also float the output driver, set the driven level, read back the pin level, set a debounce threshold and clear a latched interrupt. The port drives a tristate enable and a data bit per pad. It samples each pad through a two-flop synchroniser followed by a debounce filter.

Each pin can flag an interrupt on a level or on edges. A two-bit trigger type field selects none, level, one edge or both edges, and a separate polarity bit picks high/rising or low/falling. One port-wide status word collects the pending bits. A single interrupt output is the OR of the pending bits of pins that are enabled and have their interrupt enable set.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads 0, no pad is driven (`pad_oe` all 0) and `irq` is 0.
- R2: Pin p's window starts at byte address p*0x20. Config is at +0x00 with bit 0 pin enable, bit 1 output direction, bits 3:2 trigger type, bit 4 polarity and bit 6 interrupt enable; all other config bits read 0. Debounce threshold is at +0x04 in bits 7:0. Float control is at +0x0C in bit 0. Output level is at +0x10 in bit 0.
- R3: `pad_oe[p]` is 1 exactly when pin p is enabled, set to output and not floated. `pad_out[p]` follows the output level bit.
- R4: Bit 0 of +0x08 returns the filtered pad level when the pin is an input and the output level bit when it is an output.
- R5: A pad change enters a 2-flop synchroniser. With threshold T, the new level becomes visible after the (3+T)-th rising clock edge following the change. T=0 gives the plain synchronised level. A pulse that lasts T cycles or fewer is rejected.
- R6: Trigger type 2 latches a pending bit on a rising filtered edge when polarity is 1, and on a falling edge when polarity is 0. Type 3 latches on both edges and ignores polarity. A latched bit stays set until cleared.
- R7: Trigger type 1 makes the pin pending while the filtered level equals the polarity bit (1 = high, 0 = low). A clear does not remove it while that level persists.
- R8: Writing 1 in bit 0 of +0x14 clears pin p's latched bit. Writing 0 there has no effect, and +0x14 reads 0.
- R9: Trigger type 0 never makes the pin pending.
- R10: The word at 0x104 holds pending bit p in bit p, whatever the pin and interrupt enables are.
- R11: `irq` is 1 exactly when some pin is pending with both its pin enable and its interrupt enable set.
- R12: Windows of pins at or above NUM_PINS, unused offsets and misaligned addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address for write and read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Level to drive on each pad |
| pad_oe | output | NUM_PINS | Pad driver enable per pin |
| irq | output | 1 | Port interrupt |

## Verification
The bench builds the port with NUM_PINS=6 and the default 8-bit threshold. The two address windows for pins 6 and 7 then decode but have no pin behind them, so the bench can show that R12 discards writes there and that the top status bits stay 0. With thresholds of 0 and 4 it can place a pad change on the exact edge where the filter accepts it, and place a 4-cycle glitch just below that limit.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    parameter int unsigned THR_W = 8;

    typedef enum logic [1:0] {
        TRIG_OFF        = 2'd0,
        TRIG_LEVEL      = 2'd1,
        TRIG_ONE_EDGE   = 2'd2,
        TRIG_BOTH_EDGES = 2'd3
    } trig_e;

    typedef struct packed {
        logic [THR_W-1:0] db_thr;
        logic             out_val;
        logic             float_en;
        logic             irq_en;
        logic             pol;
        trig_e            trig;
        logic             dir_out;
        logic             pin_en;
    } pin_cfg_t;

    // word index inside a pin window (byte offset / 4)
    localparam logic [2:0] W_CFG = 3'd0;
    localparam logic [2:0] W_DB  = 3'd1;
    localparam logic [2:0] W_IN  = 3'd2;
    localparam logic [2:0] W_FLT = 3'd3;
    localparam logic [2:0] W_OUT = 3'd4;
    localparam logic [2:0] W_CLR = 3'd5;

    localparam logic [8:0] STATUS_ADDR = 9'h104;

endpackage

// File: rtl/gpio_pin_filter.sv
`timescale 1ns/1ps
module gpio_pin_filter #(
    parameter int unsigned THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             level_o
);

    typedef struct packed {
        logic             meta;
        logic             sync;
        logic             level;
        logic [THR_W-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pad_i;
        st_d.sync = st_q.meta;
        if (st_q.sync != st_q.level) begin
            if (st_q.cnt >= thr_i) begin
                st_d.level = st_q.sync;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

    // R5: the accepted level only moves when the synchronised input disagrees
    a_r5_hold_when_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sync == st_q.level) |=> $stable(st_q.level));

    // R5: a zero threshold passes the synchronised level straight through
    a_r5_zero_thr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i == '0) |=> (st_q.level == $past(st_q.sync)));

endmodule

// File: rtl/gpio_pin_trig.sv
`timescale 1ns/1ps
module gpio_pin_trig
    import gpio_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  level_i,
    input  trig_e trig_i,
    input  logic  pol_i,
    input  logic  clr_i,
    output logic  pend_o
);

    typedef struct packed {
        logic prev;
        logic latch;
    } trig_state_t;

    trig_state_t st_d, st_q;
    logic rise, fall, hit, edge_mode;

    always_comb begin
        rise      = level_i & ~st_q.prev;
        fall      = ~level_i & st_q.prev;
        edge_mode = (trig_i == TRIG_ONE_EDGE) || (trig_i == TRIG_BOTH_EDGES);
        unique case (trig_i)
            TRIG_ONE_EDGE:   hit = pol_i ? rise : fall;
            TRIG_BOTH_EDGES: hit = rise | fall;
            default:         hit = 1'b0;
        endcase

        st_d      = st_q;
        st_d.prev = level_i;
        if (!edge_mode)  st_d.latch = 1'b0;
        else if (hit)    st_d.latch = 1'b1;
        else if (clr_i)  st_d.latch = 1'b0;

        if (trig_i == TRIG_LEVEL) pend_o = (level_i == pol_i);
        else                      pend_o = st_q.latch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a clear with no coincident edge empties the latch
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !st_q.latch);

    // R6: the latch only rises after the filtered level moved
    a_r6_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.latch) |-> $past(level_i != st_q.prev));

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            rdata_o,
    input  logic [NUM_PINS-1:0]          level_i,
    input  logic [NUM_PINS-1:0]          pend_i,
    output pin_cfg_t [NUM_PINS-1:0]      cfg_o,
    output logic [NUM_PINS-1:0]          clr_o
);

    localparam int unsigned SLOT_W = 3;

    typedef struct packed {
        pin_cfg_t [NUM_PINS-1:0] cfg;
    } regs_state_t;

    regs_state_t st_d, st_q;

    logic              hi_zero, pin_space, status_hit;
    logic [SLOT_W-1:0] slot;
    logic [2:0]        word;

    always_comb begin
        hi_zero    = ((addr_i >> 9) == '0);
        pin_space  = hi_zero && (addr_i[8] == 1'b0) && (addr_i[1:0] == 2'b00);
        status_hit = hi_zero && (addr_i[8:0] == STATUS_ADDR);
        slot       = addr_i[7:5];
        word       = addr_i[4:2];

        st_d  = st_q;
        clr_o = '0;
        rdata_o = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pin_space && slot == SLOT_W'(i)) begin
                if (wr_en_i) begin
                    case (word)
                        W_CFG: begin
                            st_d.cfg[i].pin_en  = wdata_i[0];
                            st_d.cfg[i].dir_out = wdata_i[1];
                            st_d.cfg[i].trig    = trig_e'(wdata_i[3:2]);
                            st_d.cfg[i].pol     = wdata_i[4];
                            st_d.cfg[i].irq_en  = wdata_i[6];
                        end
                        W_DB:  st_d.cfg[i].db_thr   = wdata_i[THR_W-1:0];
                        W_FLT: st_d.cfg[i].float_en = wdata_i[0];
                        W_OUT: st_d.cfg[i].out_val  = wdata_i[0];
                        W_CLR: clr_o[i]             = wdata_i[0];
                        default: ;
                    endcase
                end
                case (word)
                    W_CFG: begin
                        rdata_o[0]   = st_q.cfg[i].pin_en;
                        rdata_o[1]   = st_q.cfg[i].dir_out;
                        rdata_o[3:2] = st_q.cfg[i].trig;
                        rdata_o[4]   = st_q.cfg[i].pol;
                        rdata_o[6]   = st_q.cfg[i].irq_en;
                    end
                    W_DB:  rdata_o[THR_W-1:0] = st_q.cfg[i].db_thr;
                    W_IN:  rdata_o[0] = st_q.cfg[i].dir_out ? st_q.cfg[i].out_val
                                                            : level_i[i];
                    W_FLT: rdata_o[0] = st_q.cfg[i].float_en;
                    W_OUT: rdata_o[0] = st_q.cfg[i].out_val;
                    default: ;
                endcase
            end
        end
        if (status_hit) rdata_o[NUM_PINS-1:0] = pend_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    // R2: a config write to pin 0 lands in the enable fields on the next cycle
    a_r2_cfg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(0)) |=>
        (st_q.cfg[0].pin_en == $past(wdata_i[0]) &&
         st_q.cfg[0].irq_en == $past(wdata_i[6])));

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);

    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0]     level, pend, clr, armed;

    gpio_port_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (bus_wr_en),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .level_i (level),
        .pend_i  (pend),
        .cfg_o   (cfg),
        .clr_o   (clr)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_filter #(.THR_W(THR_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_i   (pad_in[p]),
            .thr_i   (cfg[p].db_thr),
            .level_o (level[p])
        );

        gpio_pin_trig u_trig (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (level[p]),
            .trig_i  (cfg[p].trig),
            .pol_i   (cfg[p].pol),
            .clr_i   (clr[p]),
            .pend_o  (pend[p])
        );

        assign pad_out[p] = cfg[p].out_val;
        assign pad_oe[p]  = cfg[p].pin_en & cfg[p].dir_out & ~cfg[p].float_en;
        assign armed[p]   = pend[p] & cfg[p].irq_en & cfg[p].pin_en;
    end

    assign irq = |armed;

    // R9: a pin with trigger type off never reports pending one cycle later
    a_r9_off_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[0].trig == TRIG_OFF && $stable(cfg[0].trig)) |-> !pend[0]);

endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic [8:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_port #(.NUM_PINS(NP), .ADDR_W(9), .DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [8:0] ra(int pin, int wordi);
        return 9'(pin * 32 + wordi * 4);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(ra(0, 0), d); check("R1 cfg0", d, 0);
        rd(ra(5, 1), d); check("R1 db5", d, 0);
        rd(9'h104, d);   check("R1 status", d, 0);
        check("R1 pad_oe", 32'(pad_oe), 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(ra(2, 0), 32'hFFFF_FFFF); rd(ra(2, 0), d); check("R2 cfg mask", d, 32'h5F);
        wr(ra(2, 1), 32'h1FF);       rd(ra(2, 1), d); check("R2 db thr", d, 32'hFF);
        wr(ra(2, 3), 32'hF);         rd(ra(2, 3), d); check("R2 float", d, 1);
        wr(ra(2, 4), 32'h3);         rd(ra(2, 4), d); check("R2 outval", d, 1);
        rd(ra(2, 5), d); check("R8 clear reads 0", d, 0);
        wr(ra(2, 0), 0); wr(ra(2, 1), 0); wr(ra(2, 3), 0); wr(ra(2, 4), 0);
    endtask

    task automatic t_drive();
        logic [31:0] d;
        pad_in[1] = 1'b0;
        wr(ra(1, 4), 1); wr(ra(1, 0), 32'h3);
        check("R3 oe on", 32'(pad_oe[1]), 1);
        check("R3 out lvl", 32'(pad_out[1]), 1);
        rd(ra(1, 2), d); check("R4 out readback", d, 1);
        wr(ra(1, 3), 1); check("R3 floated", 32'(pad_oe[1]), 0);
        wr(ra(1, 3), 0); wr(ra(1, 0), 32'h1);
        check("R3 input dir", 32'(pad_oe[1]), 0);
        pad_in[1] = 1'b1; step(4);
        rd(ra(1, 2), d); check("R4 input pad", d, 1);
        pad_in[1] = 1'b0; wr(ra(1, 0), 0); wr(ra(1, 4), 0); step(4);
    endtask

    task automatic t_debounce();
        logic [31:0] d;
        wr(ra(3, 1), 4); wr(ra(3, 0), 1);
        pad_in[3] = 1'b1; step(4); pad_in[3] = 1'b0; step(10);
        rd(ra(3, 2), d); check("R5 glitch rejected", d, 0);
        pad_in[3] = 1'b1; step(6);
        rd(ra(3, 2), d); check("R5 thr4 before", d, 0);
        step(1);
        rd(ra(3, 2), d); check("R5 thr4 accept", d, 1);
        pad_in[4] = 1'b1; step(2);
        rd(ra(4, 2), d); check("R5 thr0 before", d, 0);
        step(1);
        rd(ra(4, 2), d); check("R5 thr0 accept", d, 1);
        pad_in[3] = 1'b0; pad_in[4] = 1'b0; wr(ra(3, 0), 0); step(10);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(ra(0, 0), 32'h59);                // en, one edge, rising, ie
        pad_in[0] = 1'b1; step(6);
        rd(9'h104, d); check("R6 rise pend", d, 1);
        check("R11 irq", 32'(irq), 1);
        wr(ra(0, 5), 0); rd(9'h104, d); check("R8 write0 no effect", d, 1);
        wr(ra(0, 5), 1); rd(9'h104, d); check("R8 clear", d, 0);
        check("R11 irq low", 32'(irq), 0);
        pad_in[0] = 1'b0; step(6);
        rd(9'h104, d); check("R6 fall ignored", d, 0);
        wr(ra(0, 0), 32'h49);                // falling
        pad_in[0] = 1'b1; step(6);
        rd(9'h104, d); check("R6 rise ignored", d, 0);
        pad_in[0] = 1'b0; step(6);
        rd(9'h104, d); check("R6 fall pend", d, 1);
        wr(ra(0, 5), 1);
        wr(ra(0, 0), 32'h5D);                // both edges, polarity ignored
        pad_in[0] = 1'b1; step(6);
        rd(9'h104, d); check("R6 both rise", d, 1);
        wr(ra(0, 5), 1); pad_in[0] = 1'b0; step(6);
        rd(9'h104, d); check("R6 both fall", d, 1);
        wr(ra(0, 5), 1); step(1);
        rd(9'h104, d); check("R6 stays clear", d, 0);
    endtask

    task automatic t_ie_gate();
        logic [31:0] d;
        wr(ra(0, 0), 32'h19);                // rising, no ie
        pad_in[0] = 1'b1; step(6);
        rd(9'h104, d); check("R10 pend without ie", d, 1);
        check("R11 ie off", 32'(irq), 0);
        wr(ra(0, 0), 32'h58);                // ie on, pin disabled
        rd(9'h104, d); check("R10 pend without en", d, 1);
        check("R11 en off", 32'(irq), 0);
        wr(ra(0, 0), 32'h59);
        check("R11 both on", 32'(irq), 1);
        wr(ra(0, 0), 32'h01);                // trigger off
        pad_in[0] = 1'b0; step(6); pad_in[0] = 1'b1; step(6);
        rd(9'h104, d); check("R9 off no pend", d, 0);
        pad_in[0] = 1'b0; wr(ra(0, 0), 0); step(6);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(ra(5, 0), 32'h55);                // level high
        step(2); rd(9'h104, d); check("R7 low idle", d, 0);
        pad_in[5] = 1'b1; step(5);
        rd(9'h104, d); check("R7 high pend", d, 32'h20);
        check("R11 level irq", 32'(irq), 1);
        wr(ra(5, 5), 1); step(1);
        rd(9'h104, d); check("R7 clear no effect", d, 32'h20);
        pad_in[5] = 1'b0; step(5);
        rd(9'h104, d); check("R7 released", d, 0);
        wr(ra(5, 0), 32'h45);                // level low
        rd(9'h104, d); check("R7 active low", d, 32'h20);
        wr(ra(5, 0), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(ra(6, 0), 32'hFF); rd(ra(6, 0), d); check("R12 slot6 cfg", d, 0);
        wr(ra(7, 4), 1);      rd(ra(7, 4), d); check("R12 slot7 out", d, 0);
        check("R12 no drive", 32'(pad_oe), 0);
        wr(ra(0, 6), 32'hFF); rd(ra(0, 6), d); check("R12 hole", d, 0);
        wr(9'h001, 32'h3);    rd(9'h001, d);   check("R12 misaligned", d, 0);
        rd(ra(0, 0), d); check("R12 cfg0 untouched", d, 0);
        rd(9'h100, d); check("R12 0x100", d, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_drive();
        t_debounce();
        t_edge();
        t_ie_gate();
        t_level();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule